// File: doc/BRIEF.md
# Bit-Serial Prefix-Code Symbol Decoder

This block turns a compressed stream, delivered one bit per strobe, back into 4-bit symbols. Software or a neighbouring block first fills a sixteen-entry code table. Each entry has a valid flag, a right-aligned codeword of up to six bits, the codeword's length and the symbol it stands for. While bits arrive, the decoder keeps the bits of the codeword it is currently assembling. After every new bit it compares that partial codeword against all table entries at once.

When exactly one entry matches in both length and bits, the decoder emits the symbol with a one-cycle valid pulse and goes back to its idle state, ready for the first bit of the next codeword. If six bits pile up with no match, or if an end-of-stream marker comes while a codeword is only partly received, the decoder raises a one-cycle error pulse, drops the partial bits and also goes back to idle. The code loaded into the table must be prefix-free, so no codeword is the start of another.

Top module: `huff_bitser_dec`

## Requirements
- R1: After a synchronous active-high reset, `sym_valid` and `err` are low and every table entry is invalid. With the empty table, six received bits therefore raise `err`.
- R2: A cycle with `tbl_we` high writes entry `tbl_addr` with `{tbl_vld, tbl_code, tbl_len, tbl_sym}`, replacing any earlier content. The entry is used for bits that arrive from the next cycle on.
- R3: Bit order: for an entry of length L, the first bit received must equal `tbl_code[L-1]` and the last bit must equal `tbl_code[0]`. Code bits at positions L and above are ignored.
- R4: An entry matches only when its valid flag is set, its length equals the number of bits gathered so far, and its low L code bits equal those bits. An entry whose valid flag is clear never matches.
- R5: When a bit completes a match, `sym_valid` is high for exactly the next cycle and `sym_out` carries that entry's symbol in that cycle.
- R6: After a match the next valid bit starts a new codeword, so codewords may follow one another on consecutive cycles with no gap.
- R7: Cycles with `bit_valid` and `eos` both low change no state and give no `sym_valid` or `err` pulse.
- R8: If the sixth gathered bit completes no match, `err` is high for exactly the next cycle, the partial bits are discarded and the next bit starts a new codeword.
- R9: `eos` high while a partial codeword is held gives one `err` pulse in the next cycle and discards the partial bits. A bit strobed in the same cycle as `eos` is consumed first. `eos` with no partial bits left (idle, or the same-cycle bit completed a codeword) raises no error.
- R10: `sym_valid` and `err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | `bit_in` holds a stream bit this cycle |
| bit_in | input | 1 | Serial compressed bit |
| eos | input | 1 | End-of-stream marker |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_addr | input | 4 | Table entry index |
| tbl_vld | input | 1 | Valid flag for the written entry |
| tbl_code | input | 6 | Codeword, right-aligned |
| tbl_len | input | 3 | Codeword length in bits, 1 to 6 |
| tbl_sym | input | 4 | Symbol decoded from the entry |
| sym_out | output | 4 | Decoded symbol |
| sym_valid | output | 1 | One-cycle pulse marking `sym_out` valid |
| err | output | 1 | One-cycle pulse for an unmatched codeword or an early end of stream |

## Verification
The bench loads a canonical code that leaves three six-bit patterns unused. It decodes every codeword back to back, then a long pseudo-random symbol stream with idle gaps between codewords. A decoder that reversed the bit order, mixed up codewords that share a prefix, or failed to clear its partial bits after a match would emit wrong symbols or drift out of alignment. The unused six-bit patterns and a cleared valid flag must end in an error pulse; a decoder that ignored the valid flag or the length would output a symbol there instead. End-of-stream is tried mid-codeword, at a codeword boundary and in the same cycle as a codeword's last bit. This catches a decoder that judges the marker before consuming the bit.

// File: rtl/huff_dec_pkg.sv
package huff_dec_pkg;

    localparam int SYM_W  = 4;
    localparam int CODE_W = 6;
    localparam int LEN_W  = 3;
    localparam int N_ENT  = 16;
    localparam int IDX_W  = $clog2(N_ENT);

    typedef struct packed {
        logic              vld;
        logic [CODE_W-1:0] code;
        logic [LEN_W-1:0]  len;
        logic [SYM_W-1:0]  sym;
    } tbl_ent_t;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_GATHER = 1'b1
    } dec_state_e;

    // Mask of the low n bits of a codeword.
    function automatic logic [CODE_W-1:0] len_mask(input logic [LEN_W-1:0] n);
        logic [CODE_W-1:0] m;
        for (int k = 0; k < CODE_W; k++) begin
            m[k] = (k < int'(n));
        end
        return m;
    endfunction

endpackage

// File: rtl/huff_code_table.sv
module huff_code_table
    import huff_dec_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [IDX_W-1:0]           addr,
    input  tbl_ent_t                   wdata,
    output tbl_ent_t [N_ENT-1:0]       ents
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ents <= '0;
        end else if (we) begin
            ents[addr] <= wdata;
        end
    end

endmodule

// File: rtl/huff_match_unit.sv
module huff_match_unit
    import huff_dec_pkg::*;
(
    input  tbl_ent_t [N_ENT-1:0]       ents,
    input  logic [CODE_W-1:0]          cand,
    input  logic [LEN_W-1:0]           ncnt,
    output logic                       hit,
    output logic [SYM_W-1:0]           hit_sym
);

    logic [N_ENT-1:0]  hit_vec;
    logic [CODE_W-1:0] mask;

    assign mask = len_mask(ncnt);

    for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
        assign hit_vec[i] = ents[i].vld
                         && (ents[i].len == ncnt)
                         && (((ents[i].code ^ cand) & mask) == '0);
    end

    // Prefix-free code: at most one hit; lowest index wins otherwise.
    always_comb begin
        hit     = 1'b0;
        hit_sym = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit     = 1'b1;
                hit_sym = ents[i].sym;
            end
        end
    end

endmodule

// File: rtl/huff_dec_fsm.sv
module huff_dec_fsm
    import huff_dec_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bit_valid,
    input  logic               bit_in,
    input  logic               eos,
    input  logic               hit,
    input  logic [SYM_W-1:0]   hit_sym,
    output logic [CODE_W-1:0]  cand,
    output logic [LEN_W-1:0]   ncnt,
    output logic [LEN_W-1:0]   cnt,
    output logic [SYM_W-1:0]   sym_out,
    output logic               sym_valid,
    output logic               err
);

    dec_state_e        state, nxt_state;
    logic [CODE_W-2:0] shreg, nxt_sh;
    logic [LEN_W-1:0]  nxt_cnt;
    logic              nxt_sv, nxt_err;

    assign cand = {shreg, bit_in};
    assign ncnt = cnt + 1'b1;

    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        nxt_sh    = shreg;
        nxt_sv    = 1'b0;
        nxt_err   = 1'b0;
        if (bit_valid) begin
            if (hit) begin
                nxt_sv    = 1'b1;
                nxt_cnt   = '0;
                nxt_sh    = '0;
                nxt_state = ST_IDLE;
            end else if (ncnt == LEN_W'(CODE_W)) begin
                nxt_err   = 1'b1;
                nxt_cnt   = '0;
                nxt_sh    = '0;
                nxt_state = ST_IDLE;
            end else begin
                nxt_cnt   = ncnt;
                nxt_sh    = cand[CODE_W-2:0];
                nxt_state = ST_GATHER;
            end
        end
        // End of stream judged after the same-cycle bit
        if (eos && (nxt_cnt != '0)) begin
            nxt_err   = 1'b1;
            nxt_cnt   = '0;
            nxt_sh    = '0;
            nxt_state = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            shreg     <= '0;
            sym_out   <= '0;
            sym_valid <= 1'b0;
            err       <= 1'b0;
        end else begin
            state     <= nxt_state;
            cnt       <= nxt_cnt;
            shreg     <= nxt_sh;
            sym_valid <= nxt_sv;
            err       <= nxt_err;
            if (nxt_sv) begin
                sym_out <= hit_sym;
            end
        end
    end

endmodule

// File: rtl/huff_bitser_dec.sv
module huff_bitser_dec
    import huff_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic              eos,
    input  logic              tbl_we,
    input  logic [3:0]        tbl_addr,
    input  logic              tbl_vld,
    input  logic [5:0]        tbl_code,
    input  logic [2:0]        tbl_len,
    input  logic [3:0]        tbl_sym,
    output logic [3:0]        sym_out,
    output logic              sym_valid,
    output logic              err
);

    tbl_ent_t [N_ENT-1:0] ents;
    tbl_ent_t             wdata;
    logic [CODE_W-1:0]    cand;
    logic [LEN_W-1:0]     ncnt;
    logic [LEN_W-1:0]     fsm_cnt;
    logic                 hit;
    logic [SYM_W-1:0]     hit_sym;

    assign wdata = '{vld: tbl_vld, code: tbl_code, len: tbl_len, sym: tbl_sym};

    huff_code_table u_table (
        .clk   (clk),
        .rst   (rst),
        .we    (tbl_we),
        .addr  (tbl_addr),
        .wdata (wdata),
        .ents  (ents)
    );

    huff_match_unit u_match (
        .ents    (ents),
        .cand    (cand),
        .ncnt    (ncnt),
        .hit     (hit),
        .hit_sym (hit_sym)
    );

    huff_dec_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .eos       (eos),
        .hit       (hit),
        .hit_sym   (hit_sym),
        .cand      (cand),
        .ncnt      (ncnt),
        .cnt       (fsm_cnt),
        .sym_out   (sym_out),
        .sym_valid (sym_valid),
        .err       (err)
    );

endmodule

// File: rtl/huff_dec_chk.sv
module huff_dec_chk
    import huff_dec_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bit_valid,
    input logic             eos,
    input logic             sym_valid,
    input logic             err,
    input logic [LEN_W-1:0] cnt
);

    // R10
    excl_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !(sym_valid && err));

    // R5
    sym_src_chk: assert property (@(posedge clk) disable iff (rst)
        sym_valid |-> $past(bit_valid));

    // R9
    err_src_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> ($past(bit_valid) || $past(eos)));

    // R7
    quiet_out_chk: assert property (@(posedge clk) disable iff (rst)
        (!bit_valid && !eos) |=> (!sym_valid && !err));

    // R7
    quiet_state_chk: assert property (@(posedge clk) disable iff (rst)
        (!bit_valid && !eos) |=> $stable(cnt));

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt < LEN_W'(CODE_W));

endmodule

bind huff_bitser_dec huff_dec_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .bit_valid (bit_valid),
    .eos       (eos),
    .sym_valid (sym_valid),
    .err       (err),
    .cnt       (fsm_cnt)
);

// File: tb/huff_bitser_dec_tb_top.sv
module huff_bitser_dec_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       bit_valid, bit_in, eos;
    logic       tbl_we, tbl_vld;
    logic [3:0] tbl_addr, tbl_sym;
    logic [5:0] tbl_code;
    logic [2:0] tbl_len;
    logic [3:0] sym_out;
    logic       sym_valid, err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int         lens  [16];
    logic [5:0] codes [16];
    logic [3:0] syms  [16];

    always #(CLK_PERIOD / 2) clk = ~clk;

    huff_bitser_dec dut_i (
        .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in), .eos(eos),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_vld(tbl_vld), .tbl_code(tbl_code),
        .tbl_len(tbl_len), .tbl_sym(tbl_sym),
        .sym_out(sym_out), .sym_valid(sym_valid), .err(err)
    );

    task automatic check_out(input logic xv, input logic [3:0] xs, input logic xe,
                             input string req);
        checks++;
        if (sym_valid !== xv || err !== xe || (xv && sym_out !== xs)) begin
            errors++;
            $display("FAIL %s: got sv=%b sym=%h err=%b, expected sv=%b sym=%h err=%b",
                     req, sym_valid, sym_out, err, xv, xs, xe);
        end
    endtask

    // Drive for one cycle (from a negedge), then check at the following negedge.
    task automatic step(input logic bv, input logic b, input logic e,
                        input logic xv, input logic [3:0] xs, input logic xe,
                        input string req);
        bit_valid = bv;
        bit_in    = b;
        eos       = e;
        @(negedge clk);
        bit_valid = 1'b0;
        eos       = 1'b0;
        check_out(xv, xs, xe, req);
    endtask

    task automatic send_bits(input logic [5:0] c, input int n, input logic lastv,
                             input logic [3:0] s, input logic laste,
                             input logic eos_last, input string req);
        for (int j = n - 1; j >= 0; j--) begin
            step(1'b1, c[j], (j == 0) && eos_last, (j == 0) && lastv, s,
                 (j == 0) && laste, req);
        end
    endtask

    task automatic write_ent(input int i, input logic v, input logic [5:0] c,
                             input int l, input logic [3:0] s);
        tbl_we   = 1'b1;
        tbl_addr = 4'(i);
        tbl_vld  = v;
        tbl_code = c;
        tbl_len  = 3'(l);
        tbl_sym  = s;
        @(negedge clk);
        tbl_we   = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [5:0]  code;
        logic [15:0] lf;
        int          idx;
        lens = '{2, 3, 3, 4, 4, 4, 4, 5, 5, 5, 5, 6, 6, 6, 6, 6};
        code = '0;
        for (int i = 0; i < 16; i++) begin
            if (i > 0) code = (code + 6'd1) << (lens[i] - lens[i-1]);
            codes[i] = code;
            syms[i]  = 4'((i * 5 + 9) % 16);
        end

        rst = 1'b1; bit_valid = 1'b0; bit_in = 1'b0; eos = 1'b0;
        tbl_we = 1'b0; tbl_addr = '0; tbl_vld = 1'b0; tbl_code = '0;
        tbl_len = '0; tbl_sym = '0;
        repeat (3) @(negedge clk);
        check_out(1'b0, 4'h0, 1'b0, "R1 reset outputs");
        rst = 1'b0;
        // R1: empty table, six bits end in an error
        send_bits(6'b000000, 6, 1'b0, 4'h0, 1'b1, 1'b0, "R1 empty table");

        // R2: load table
        for (int i = 0; i < 16; i++) write_ent(i, 1'b1, codes[i], lens[i], syms[i]);

        // R3 R5 R6: every codeword, back to back
        for (int i = 0; i < 16; i++)
            send_bits(codes[i], lens[i], 1'b1, syms[i], 1'b0, 1'b0, "R3_R5_R6 sweep");

        // R7: pseudo-random stream with idle gaps
        lf = 16'hACE1;
        for (int k = 0; k < 300; k++) begin
            lf  = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            idx = int'(lf[3:0]);
            send_bits(codes[idx], lens[idx], 1'b1, syms[idx], 1'b0, 1'b0, "R6 stream");
            for (int g = 0; g < int'(lf[9:8]); g++)
                step(1'b0, lf[5], 1'b0, 1'b0, 4'h0, 1'b0, "R7 idle gap");
        end
        // R7: gap inside a codeword
        step(1'b1, codes[3][3], 1'b0, 1'b0, 4'h0, 1'b0, "R7 split");
        step(1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, "R7 split gap");
        step(1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 1'b0, "R7 split gap");
        send_bits(codes[3], 3, 1'b1, syms[3], 1'b0, 1'b0, "R7 split tail");

        // R8: unused six-bit patterns, then recovery
        send_bits(6'b111111, 6, 1'b0, 4'h0, 1'b1, 1'b0, "R8 unused 111111");
        send_bits(codes[0], lens[0], 1'b1, syms[0], 1'b0, 1'b0, "R8 recovery");
        send_bits(6'b111101, 6, 1'b0, 4'h0, 1'b1, 1'b0, "R8 unused 111101");
        send_bits(6'b111110, 6, 1'b0, 4'h0, 1'b1, 1'b0, "R8 unused 111110");
        send_bits(codes[15], lens[15], 1'b1, syms[15], 1'b0, 1'b0, "R8 recovery");

        // R4: entry with clear valid flag never matches
        write_ent(0, 1'b0, codes[0], lens[0], syms[0]);
        send_bits(6'b000000, 6, 1'b0, 4'h0, 1'b1, 1'b0, "R4 invalid entry");
        // R2: overwrite with a new symbol; R3: upper code bits ignored
        write_ent(0, 1'b1, codes[0] | 6'b110000, lens[0], 4'hE);
        send_bits(codes[0], lens[0], 1'b1, 4'hE, 1'b0, 1'b0, "R2_R3 rewrite");
        write_ent(0, 1'b1, codes[0], lens[0], syms[0]);
        send_bits(codes[0], lens[0], 1'b1, syms[0], 1'b0, 1'b0, "R2 restore");

        // R9: end of stream cases
        send_bits(codes[7] >> 2, 3, 1'b0, 4'h0, 1'b0, 1'b0, "R9 partial");
        step(1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 1'b1, "R9 eos mid-codeword");
        send_bits(codes[5], lens[5], 1'b1, syms[5], 1'b0, 1'b0, "R9 after eos");
        step(1'b0, 1'b0, 1'b1, 1'b0, 4'h0, 1'b0, "R9 eos at boundary");
        send_bits(codes[9], lens[9], 1'b1, syms[9], 1'b0, 1'b1, "R9 eos with last bit");
        step(1'b1, codes[1][2], 1'b1, 1'b0, 4'h0, 1'b1, "R9 eos with first bit");
        send_bits(codes[2], lens[2], 1'b1, syms[2], 1'b0, 1'b0, "R9 R10 after eos");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule